// File: doc/BRIEF.md
# Control-Transfer Resolver

This block decides, for one control-transfer instruction at a time, whether the core redirects its program counter, and to where. It accepts a request strobe together with the current PC, a transfer kind (conditional on the flag being set or clear, direct jump, direct jump with link, register jump, register jump with link), a signed word displacement, a register target value with that register's index, and the condition flag. One cycle after the strobe it presents a registered result: a taken indication with the target that goes into the delayed-PC register, a delay-slot marker for the following instruction, a link-write request carrying the return address, and exception requests for a misaligned register target or for a linking register jump whose target is the link register itself.

The core uses it in its execute stage. Because the architecture has one branch delay slot, a taken transfer never updates the PC at once: the target is parked in the delayed PC, and the next instruction is flagged as the slot instruction. The return address written to the link register therefore skips the slot, PC+8.

Top module: `cti_resolver`

## Requirements
- R1: All outputs are registered; a request sampled on a rising edge with `req_vld` high produces its result on the outputs after that edge, and `res_vld` is high for exactly one cycle per request. After reset every output is zero.
- R2: Kind 0 (flag-set branch) is taken exactly when `flag_f` is 1; kind 1 (flag-clear branch) is taken exactly when `flag_f` is 0.
- R3: For kinds 0 to 3 the target is `pc` plus the sign-extended `disp` shifted left by two, modulo 2^32.
- R4: Kinds 3 (direct jump with link) and 5 (register jump with link), when they transfer, request a link write of `pc + 8` to register index `LINK_IDX` (default 9).
- R5: Every taken transfer raises `dslot` and `taken` together and presents the target on `dpc_tgt`; kinds 2 and 3 are always taken.
- R6: A not-taken conditional branch produces `taken`=0, `dslot`=0, `dpc_tgt`=0 and no link write.
- R7: For kinds 4 and 5 the target is `rtgt`; if `rtgt[1:0]` is nonzero, `exc_align` is raised and there is no transfer, delay slot or link write.
- R8: Kind 5 with `rtgt_idx == LINK_IDX` raises `exc_illegal` and suppresses the transfer, link write and alignment exception, even if the target is also misaligned.
- R9: Kind codes 6 and 7 are unused and produce a result with no transfer, no link write and no exception; at most one of `taken`, `exc_align`, `exc_illegal` is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| kind | input | 3 | Transfer kind code |
| pc | input | 32 | Address of the transfer instruction |
| disp | input | 26 | Signed word displacement |
| rtgt | input | 32 | Register target value |
| rtgt_idx | input | 5 | Index of the register supplying the target |
| flag_f | input | 1 | Condition flag |
| res_vld | output | 1 | Result valid, one cycle after the request |
| taken | output | 1 | Transfer is taken |
| dpc_tgt | output | 32 | Value to load into the delayed PC |
| dslot | output | 1 | Next instruction is a delay-slot instruction |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Return address to write |
| exc_align | output | 1 | Alignment exception request |
| exc_illegal | output | 1 | Illegal-instruction exception request |

## Verification
The two checks that can strike the same request are the illegal-link test and the alignment test: a linking register jump naming the link register with a target whose low bits are nonzero satisfies both. The bench issues such requests with every nonzero low-bit pattern and expects only `exc_illegal`, with `exc_align`, `taken` and `link_we` low. It also pairs the same misaligned target with a different register index, where the alignment exception must then appear, so that the priority is judged rather than either test alone.

// File: rtl/cti_pkg.sv
package cti_pkg;
  typedef enum logic [2:0] {
    K_BR_SET  = 3'd0,
    K_BR_CLR  = 3'd1,
    K_JMP     = 3'd2,
    K_JMP_LNK = 3'd3,
    K_JREG    = 3'd4,
    K_JREG_LNK= 3'd5
  } cti_kind_e;

  typedef struct packed {
    logic        taken;
    logic [31:0] tgt;
    logic        lnk_we;
    logic        exc_align;
    logic        exc_illegal;
  } cti_res_t;
endpackage

// File: rtl/cti_decode.sv
module cti_decode #(
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 9
) (
  input  logic [2:0]       kind,
  input  logic             flag_f,
  input  logic [IDX_W-1:0] rtgt_idx,
  input  logic [1:0]       rtgt_lo,
  output logic             use_reg,
  output logic             want_xfer,
  output logic             want_link,
  output logic             bad_align,
  output logic             bad_link
);
  import cti_pkg::*;
  logic is_reg;
  always_comb begin
    want_xfer = 1'b0;
    want_link = 1'b0;
    is_reg    = 1'b0;
    case (kind)
      K_BR_SET:   want_xfer = flag_f;
      K_BR_CLR:   want_xfer = ~flag_f;
      K_JMP:      want_xfer = 1'b1;
      K_JMP_LNK:  begin want_xfer = 1'b1; want_link = 1'b1; end
      K_JREG:     begin want_xfer = 1'b1; is_reg = 1'b1; end
      K_JREG_LNK: begin want_xfer = 1'b1; want_link = 1'b1; is_reg = 1'b1; end
      default:    ;
    endcase
  end
  assign use_reg   = is_reg;
  // illegal link check outranks the alignment check
  assign bad_link  = (kind == K_JREG_LNK) && (rtgt_idx == IDX_W'(LINK_IDX));
  assign bad_align = is_reg && !bad_link && (rtgt_lo != 2'b00);
endmodule

// File: rtl/cti_target.sv
module cti_target #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 26
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   rtgt,
  input  logic              use_reg,
  output logic [XLEN-1:0]   tgt,
  output logic [XLEN-1:0]   ret_addr
);
  localparam int SHIFT_W = DISP_W + 2;
  logic [XLEN-1:0] disp_x;
  generate
    if (XLEN > SHIFT_W) begin : g_sext
      assign disp_x = {{(XLEN-SHIFT_W){disp[DISP_W-1]}}, disp, 2'b00};
    end else begin : g_trunc
      logic [SHIFT_W-1:0] sh;
      assign sh     = {disp, 2'b00};
      assign disp_x = sh[XLEN-1:0];
    end
  endgenerate
  assign tgt      = use_reg ? rtgt : (pc + disp_x);
  assign ret_addr = pc + XLEN'(8);
endmodule

// File: rtl/cti_resolver.sv
module cti_resolver #(
  parameter int XLEN     = 32,
  parameter int DISP_W   = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   rtgt,
  input  logic [IDX_W-1:0]  rtgt_idx,
  input  logic              flag_f,
  output logic              res_vld,
  output logic              taken,
  output logic [XLEN-1:0]   dpc_tgt,
  output logic              dslot,
  output logic              link_we,
  output logic [IDX_W-1:0]  link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              exc_align,
  output logic              exc_illegal
);
  logic use_reg, want_xfer, want_link, bad_align, bad_link;
  logic [XLEN-1:0] tgt, ret_addr;

  cti_decode #(.IDX_W(IDX_W), .LINK_IDX(LINK_IDX)) u_dec (
    .kind(kind), .flag_f(flag_f), .rtgt_idx(rtgt_idx), .rtgt_lo(rtgt[1:0]),
    .use_reg(use_reg), .want_xfer(want_xfer), .want_link(want_link),
    .bad_align(bad_align), .bad_link(bad_link));

  cti_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .pc(pc), .disp(disp), .rtgt(rtgt), .use_reg(use_reg),
    .tgt(tgt), .ret_addr(ret_addr));

  logic            go;
  logic            vld_d, tk_d, lw_d, ea_d, ei_d;
  logic [XLEN-1:0] tgt_d, lv_d;
  logic            vld_q, tk_q, lw_q, ea_q, ei_q;
  logic [XLEN-1:0] tgt_q, lv_q;

  always_comb begin
    go    = req_vld && want_xfer && !bad_align && !bad_link;
    vld_d = req_vld;
    tk_d  = go;
    tgt_d = go ? tgt : '0;
    lw_d  = go && want_link;
    lv_d  = (go && want_link) ? ret_addr : '0;
    ea_d  = req_vld && bad_align;
    ei_d  = req_vld && bad_link;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0; tk_q <= 1'b0; lw_q <= 1'b0; ea_q <= 1'b0; ei_q <= 1'b0;
      tgt_q <= '0;   lv_q <= '0;
    end else begin
      vld_q <= vld_d; tk_q <= tk_d; lw_q <= lw_d; ea_q <= ea_d; ei_q <= ei_d;
      tgt_q <= tgt_d; lv_q <= lv_d;
    end
  end

  assign res_vld     = vld_q;
  assign taken       = tk_q;
  assign dslot       = tk_q;
  assign dpc_tgt     = tgt_q;
  assign link_we     = lw_q;
  assign link_idx    = lw_q ? IDX_W'(LINK_IDX) : '0;
  assign link_val    = lv_q;
  assign exc_align   = ea_q;
  assign exc_illegal = ei_q;

  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(req_vld));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, exc_align, exc_illegal}));
  a_r5_no_result_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(taken || link_we || exc_align || exc_illegal));
  a_r4_link_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (kind == 3'd3)) |=> (link_we && link_val == $past(pc) + 32'd8));
  a_r8_illegal_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && kind == 3'd5 && rtgt_idx == IDX_W'(LINK_IDX)) |=> (exc_illegal && !exc_align && !link_we));
  a_r2_brset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && kind == 3'd0) |=> (taken == $past(flag_f)));
  a_r7_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && kind == 3'd4 && rtgt[1:0] != 2'b00) |=> (exc_align && !taken));
endmodule

// File: tb/cti_resolver_bench.sv
module cti_resolver_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_vld = 0, flag_f = 0;
  logic [2:0] kind = 0;
  logic [31:0] pc = 0, rtgt = 0;
  logic [25:0] disp = 0;
  logic [4:0] rtgt_idx = 0;
  logic res_vld, taken, dslot, link_we, exc_align, exc_illegal;
  logic [31:0] dpc_tgt, link_val;
  logic [4:0] link_idx;

  cti_resolver u_cti_resolver (.*);

  typedef struct {
    logic tk; logic [31:0] tgt; logic lw; logic [31:0] lv;
    logic ea; logic ei; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // driver: model from requirements
  task automatic send(string tag, logic [2:0] k, logic [31:0] p, logic [25:0] d,
                      logic [31:0] rt, logic [4:0] ri, logic f);
    exp_t e;
    logic xfer, isreg, ill, mis, lnk;
    isreg = (k == 4) || (k == 5);
    lnk   = (k == 3) || (k == 5);
    xfer  = (k == 0) ? f : (k == 1) ? !f : (k <= 5);
    ill   = (k == 5) && (ri == 5'd9);
    mis   = isreg && !ill && (rt[1:0] != 0);
    e.tk  = xfer && !ill && !mis;
    e.tgt = !e.tk ? 32'd0 : isreg ? rt : p + ({{6{d[25]}}, d} << 2);
    e.lw  = e.tk && lnk;
    e.lv  = e.lw ? p + 32'd8 : 32'd0;
    e.ea  = mis; e.ei = ill; e.tag = tag;
    @(negedge clk);
    req_vld = 1; kind = k; pc = p; disp = d; rtgt = rt; rtgt_idx = ri; flag_f = f;
    q.push_back(e);
    @(negedge clk);
    req_vld = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_vld) begin
        exp_t e;
        if (q.size() == 0) chk("R1 unexpected result", 1, 0);
        else begin
          e = q.pop_front();
          chk({e.tag, " taken"}, taken, e.tk);
          chk({e.tag, " R5 dslot"}, dslot, e.tk);
          chk({e.tag, " target"}, dpc_tgt, e.tgt);
          chk({e.tag, " R4 link_we"}, link_we, e.lw);
          chk({e.tag, " R4 link_val"}, link_val, e.lv);
          if (e.lw) chk({e.tag, " R4 link_idx"}, link_idx, 9);
          chk({e.tag, " R7 align"}, exc_align, e.ea);
          chk({e.tag, " R8 illegal"}, exc_illegal, e.ei);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset res_vld", res_vld, 0);
    chk("R1 reset taken", taken, 0);
    chk("R1 reset target", dpc_tgt, 0);
    rst_n = 1;
    send("R2 brset F=1", 0, 32'h1000, 26'd4, 0, 0, 1);
    send("R2 brset F=0 R6", 0, 32'h1000, 26'd4, 0, 0, 0);
    send("R2 brclr F=0", 1, 32'h2000, 26'h3FFFFFF, 0, 0, 0);
    send("R2 brclr F=1 R6", 1, 32'h2000, 26'd8, 0, 0, 1);
    send("R3 jmp back", 2, 32'h0000_0010, 26'h3FFFFF0, 0, 0, 0);
    send("R3 jmp wrap", 2, 32'hFFFF_FFF0, 26'd8, 0, 0, 1);
    send("R3 jmp max", 2, 32'h4000_0000, 26'h1FFFFFF, 0, 0, 0);
    send("R4 jal", 3, 32'h0000_0100, 26'd16, 0, 0, 0);
    send("R4 jal wrap", 3, 32'hFFFF_FFFC, 26'd1, 0, 0, 0);
    send("R7 jr ok", 4, 32'h500, 0, 32'h0000_8000, 5'd3, 0);
    send("R4 jalr ok", 5, 32'h600, 0, 32'h0000_9004, 5'd4, 0);
    for (int b = 1; b < 4; b++) begin
      send("R7 jr mis", 4, 32'h700, 0, 32'h100 | b, 5'd3, 0);
      send("R7 jalr mis", 5, 32'h700, 0, 32'h100 | b, 5'd9 ^ 5'd1, 0);
      send("R8 jalr lr mis", 5, 32'h700, 0, 32'h100 | b, 5'd9, 0);
    end
    send("R8 jalr lr ok", 5, 32'h800, 0, 32'h200, 5'd9, 0);
    send("R7 jr lr idx ok", 4, 32'h800, 0, 32'h200, 5'd9, 0);
    send("R9 kind6", 6, 32'h900, 26'd4, 32'h1, 5'd9, 1);
    send("R9 kind7", 7, 32'h900, 26'd4, 32'h0, 5'd9, 0);
    // back-to-back requests
    @(negedge clk);
    req_vld = 1; kind = 2; pc = 32'h10; disp = 26'd1;
    q.push_back('{1, 32'h14, 0, 0, 0, 0, "R1 b2b a"});
    @(negedge clk);
    kind = 3; pc = 32'h20; disp = 26'd2;
    q.push_back('{1, 32'h28, 1, 32'h28, 0, 0, "R1 b2b b"});
    @(negedge clk);
    req_vld = 0;
    repeat (3) @(negedge clk);
    chk("R1 idle res_vld", res_vld, 0);
    chk("R1 queue drained", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule